// File: doc/BRIEF.md
# Raster 3x3 Weighted Window Filter

This block smooths an 8-bit image that arrives as a stream of pixel columns. Each accepted column carries three vertically adjacent pixels: the row above, the current row and the row below. The columns of one scan line come in left to right. Successive lines follow each other in the same way. A 3-by-3 window register array keeps the three most recent columns of the current line. Each new column moves the older two one place left and lands in the rightmost slot, so each pixel is read from the stream only once per line pass.

Once a line has delivered three columns, the window is complete and the block forms a weighted sum of all nine pixels. Every weight is 1, 2 or 4, so each tap is a plain wire or a fixed left shift rather than a multiplier. The sum is divided by a power of two and registered. It leaves on an output stream together with the column and line coordinates of the centre pixel. Results never go back into the window, so every later window sees only original input pixels. The first and last column of a line are never a centre and produce no output.

Top module: `rasterWindowFilter`

## Requirements
- R1: While reset is asserted, and after it is released with no column offered, `outValid` is 0 and `outPixel`, `outX` and `outY` are all zero.
- R2: A column is accepted only on a clock edge where `colValid` is 1. `lineStart` is sampled only together with `colValid` and marks the accepted column as column 0 of a new line. A `lineStart` pulse without `colValid` has no effect on coordinates, window or outputs.
- R3: When the accepted column has index 2 or higher within its line, `outValid` is 1 for exactly one cycle, starting on the second rising edge after the accepting edge. Columns 0 and 1 of a line produce no output, and the outputs are otherwise 0 on `outValid`.
- R4: `outPixel` equals floor((1·a + 2·b + 1·c + 2·d + 4·e + 2·f + 1·g + 2·h + 1·i) / 16). Here a,b,c are the `colTop` values of the three window columns from oldest to newest, d,e,f are the `colMid` values and g,h,i are the `colBot` values.
- R5: `outX` is the line-relative index of the centre column, one less than the index of the column that completed the window. `outY` is 0 for the first line after reset and increases by one for every later line start.
- R6: Idle cycles between accepted columns leave the window and coordinates unchanged. Results match those of the same columns sent back to back.
- R7: The filtered value is never written back into the window. A single bright pixel gives each of the three outputs it touches its own tap weight times the pixel value, divided by 16.
- R8: Columns accepted after reset but before the first `lineStart` produce no output.
- R9: A `lineStart` in the middle of a line discards the partial window. No output follows until three columns of the new line are in, and no output mixes pixels of two lines.
- R10: An all-255 window yields 255 and an all-zero window yields 0, with no overflow in the 12-bit internal sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| colValid | input | 1 | A new column is offered this cycle |
| lineStart | input | 1 | With colValid: this column is column 0 of a new line |
| colTop | input | 8 | Pixel of the row above the centre row |
| colMid | input | 8 | Pixel of the centre row |
| colBot | input | 8 | Pixel of the row below the centre row |
| outValid | output | 1 | One-cycle strobe for a filtered centre pixel |
| outPixel | output | 8 | Filtered centre pixel value |
| outX | output | 8 | Column index of the centre pixel within its line |
| outY | output | 8 | Line ordinal of the centre pixel |

## Verification
The bench sends a spike through each of the nine window positions in turn. A swapped or wrongly shifted tap weight, or a design that wrote its result back into the window, would show as a wrong value on one of those positions. Lines are restarted midway, and columns arrive before any line start. A column counter that failed to reset on a line start would emit windows that straddle two lines, with wrong values and wrong `outX`. Gaps in `colValid` and lone `lineStart` pulses test whether the design shifts only on accepted columns: a design that shifted on idle cycles would give wrong values or extra outputs. Long random sweeps and full-scale frames compare every value, coordinate and arrival cycle against arithmetic done in the bench. These cover an off-by-one in latency and a truncated sum that wraps at 255.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  // side of the square filter window
  localparam int WIN = 3;
  // number of taps in the window
  localparam int TAPS = WIN * WIN;

  // strobes sent from the control path to the datapath
  typedef struct packed {
    logic shift;    // an accepted column enters the window this edge
    logic capture;  // the window holds a complete window: register its sum
  } rwfStrobes_t;

endpackage

// File: rtl/rwfControl.sv
module rwfControl
  import rwf_pkg::*;
#(
  parameter int X_W = 8,
  parameter int Y_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             colValid,
  input  logic             lineStart,
  output rwfStrobes_t      strobes,
  output logic             outValid,
  output logic [X_W-1:0]   outX,
  output logic [Y_W-1:0]   outY
);

  localparam logic [X_W-1:0] X_MAX   = '1;
  localparam logic [X_W-1:0] X_FULL  = X_W'(WIN - 1);

  logic             inLine;
  logic [X_W-1:0]   colIdx;
  logic [X_W-1:0]   newIdx;
  logic [Y_W-1:0]   lineIdx;
  logic             completeNow;
  logic             captureQ;
  logic [X_W-1:0]   pendX;
  logic [Y_W-1:0]   pendY;

  // index of the column offered this cycle, saturating at the top
  always_comb begin
    if (lineStart) begin
      newIdx = '0;
    end else if (colIdx == X_MAX) begin
      newIdx = colIdx;
    end else begin
      newIdx = colIdx + 1'b1;
    end
  end

  // the offered column completes a window of the current line
  assign completeNow = colValid && inLine && !lineStart && (newIdx >= X_FULL);

  // line and column position tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inLine  <= 1'b0;
      colIdx  <= '0;
      lineIdx <= '0;
    end else if (colValid) begin
      if (lineStart) begin
        inLine  <= 1'b1;
        colIdx  <= '0;
        lineIdx <= inLine ? lineIdx + 1'b1 : '0;
      end else if (inLine) begin
        colIdx  <= newIdx;
      end
    end
  end

  // one stage: window complete -> capture strobe with coordinates
  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureQ <= 1'b0;
      pendX    <= '0;
      pendY    <= '0;
    end else begin
      captureQ <= completeNow;
      if (completeNow) begin
        pendX <= newIdx - 1'b1;
        pendY <= lineIdx;
      end
    end
  end

  // second stage: coordinates leave alongside the registered result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outX     <= '0;
      outY     <= '0;
    end else begin
      outValid <= captureQ;
      if (captureQ) begin
        outX <= pendX;
        outY <= pendY;
      end
    end
  end

  always_comb begin
    strobes.shift   = colValid;
    strobes.capture = captureQ;
  end

endmodule

// File: rtl/rwfDatapath.sv
module rwfDatapath
  import rwf_pkg::*;
#(
  parameter int                  PIX_W         = 8,
  parameter logic [2*TAPS-1:0]   WEIGHT_SHIFTS = 18'b00_01_00_01_10_01_00_01_00,
  parameter int                  OUT_SHIFT     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  rwfStrobes_t        strobes,
  input  logic [PIX_W-1:0]   colTop,
  input  logic [PIX_W-1:0]   colMid,
  input  logic [PIX_W-1:0]   colBot,
  output logic [PIX_W-1:0]   outPixel
);

  // weights of 1, 2, 4 summing to at most 16 fit in PIX_W + 4 bits
  localparam int SUM_W = PIX_W + 4;

  logic [PIX_W-1:0] win [WIN][WIN];   // [row][column], column 0 oldest
  logic [PIX_W-1:0] newCol [WIN];
  logic [SUM_W-1:0] term [TAPS];
  logic [SUM_W-1:0] windowSum;

  always_comb begin
    newCol[0] = colTop;
    newCol[1] = colMid;
    newCol[2] = colBot;
  end

  // window register array with a left shift path per row
  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rstN) begin
          win[r][c] <= '0;
        end else if (strobes.shift) begin
          if (c == WIN - 1) begin
            win[r][c] <= newCol[r];
          end else begin
            win[r][c] <= win[r][c+1];
          end
        end
      end
    end
  end

  // each tap is a fixed shift of its pixel: a wire for 1, one or two bits for 2, 4
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [1:0] SH = WEIGHT_SHIFTS[2*k +: 2];
    assign term[k] = SUM_W'(win[k / WIN][k % WIN]) << SH;
  end

  // combinational weighted sum from the window registers
  always_comb begin
    windowSum = '0;
    for (int k = 0; k < TAPS; k++) begin
      windowSum = windowSum + term[k];
    end
  end

  // result register, separate from the window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPixel <= '0;
    end else if (strobes.capture) begin
      outPixel <= PIX_W'(windowSum >> OUT_SHIFT);
    end
  end

endmodule

// File: rtl/rasterWindowFilter.sv
module rasterWindowFilter
  import rwf_pkg::*;
#(
  parameter int                  PIX_W         = 8,
  parameter int                  X_W           = 8,
  parameter int                  Y_W           = 8,
  parameter logic [2*TAPS-1:0]   WEIGHT_SHIFTS = 18'b00_01_00_01_10_01_00_01_00,
  parameter int                  OUT_SHIFT     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               colValid,
  input  logic               lineStart,
  input  logic [PIX_W-1:0]   colTop,
  input  logic [PIX_W-1:0]   colMid,
  input  logic [PIX_W-1:0]   colBot,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPixel,
  output logic [X_W-1:0]     outX,
  output logic [Y_W-1:0]     outY
);

  rwfStrobes_t strobes;

  rwfControl #(
    .X_W (X_W),
    .Y_W (Y_W)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .colValid  (colValid),
    .lineStart (lineStart),
    .strobes   (strobes),
    .outValid  (outValid),
    .outX      (outX),
    .outY      (outY)
  );

  rwfDatapath #(
    .PIX_W         (PIX_W),
    .WEIGHT_SHIFTS (WEIGHT_SHIFTS),
    .OUT_SHIFT     (OUT_SHIFT)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .colTop   (colTop),
    .colMid   (colMid),
    .colBot   (colBot),
    .outPixel (outPixel)
  );

endmodule

// File: rtl/rasterWindowFilterChecker.sv
module rasterWindowFilterChecker #(
  parameter int X_W = 8,
  parameter int Y_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             colValid,
  input logic             lineStart,
  input logic             outValid,
  input logic [X_W-1:0]   outX,
  input logic [Y_W-1:0]   outY
);

  // R3: an output needs a column accepted two edges earlier
  p_valid_needs_column_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(colValid, 2));

  // R3: a line's first column never completes a window
  p_first_column_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && lineStart) |=> ##1 !outValid);

  // R5: the first column of a line is never a centre
  p_centre_not_left_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outX != '0));

  // R5: back-to-back outputs step one column right (or hold at saturation)
  p_x_advances_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |->
      ((outX == X_W'($past(outX) + 1'b1)) || (outX == $past(outX))));

  // R9: back-to-back outputs always belong to the same line
  p_y_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outY == $past(outY)));

endmodule

bind rasterWindowFilter rasterWindowFilterChecker #(
  .X_W (X_W),
  .Y_W (Y_W)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .colValid  (colValid),
  .lineStart (lineStart),
  .outValid  (outValid),
  .outX      (outX),
  .outY      (outY)
);

// File: tb/test_rasterWindowFilter.sv
module test_rasterWindowFilter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       colValid = 1'b0;
  logic       lineStart = 1'b0;
  logic [7:0] colTop = '0;
  logic [7:0] colMid = '0;
  logic [7:0] colBot = '0;
  logic       outValid;
  logic [7:0] outPixel;
  logic [7:0] outX;
  logic [7:0] outY;

  always #10 clk = ~clk;   // 50 MHz

  rasterWindowFilter i_rasterWindowFilter (
    .clk (clk), .rstN (rstN), .colValid (colValid), .lineStart (lineStart),
    .colTop (colTop), .colMid (colMid), .colBot (colBot),
    .outValid (outValid), .outPixel (outPixel), .outX (outX), .outY (outY)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit doneFlag = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected output queue
  int    expVal [0:4095];
  int    expX   [0:4095];
  int    expY   [0:4095];
  int    expCyc [0:4095];
  string expTag [0:4095];
  int    wr = 0;
  int    rd = 0;

  // bench model of the stream position and window (from the requirements)
  int mWin [3][3];
  int mX = 0;
  int mY = 0;
  bit mInLine = 0;
  int weight [3][3] = '{'{1, 2, 1}, '{2, 4, 2}, '{1, 2, 1}};
  int unsigned seed = 32'h1234_5678;

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  function automatic int windowValue();
    int acc = 0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        acc += weight[r][c] * mWin[r][c];
    return acc / 16;
  endfunction

  task automatic sendCol(input bit ls, input int t, input int m, input int b,
                         input string tag);
    @(negedge clk);
    colValid  = 1'b1;
    lineStart = ls;
    colTop    = 8'(t);
    colMid    = 8'(m);
    colBot    = 8'(b);
    if (ls) begin
      mY = mInLine ? mY + 1 : 0;
      mInLine = 1;
      mX = 0;
    end else if (mInLine) begin
      mX++;
    end
    for (int r = 0; r < 3; r++) begin
      mWin[r][0] = mWin[r][1];
      mWin[r][1] = mWin[r][2];
    end
    mWin[0][2] = t;
    mWin[1][2] = m;
    mWin[2][2] = b;
    if (!ls && mInLine && mX >= 2) begin
      expVal[wr] = windowValue();
      expX[wr]   = mX - 1;
      expY[wr]   = mY;
      expCyc[wr] = cyc + 2;
      expTag[wr] = tag;
      wr++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      colValid  = 1'b0;
      lineStart = 1'b0;
    end
  endtask

  task automatic loneLineStart();
    @(negedge clk);
    colValid  = 1'b0;
    lineStart = 1'b1;
    colTop = 8'hAA; colMid = 8'h55; colBot = 8'hFF;
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  // scoreboard on the output stream
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      if (outValid) begin
        checks++;
        if (rd >= wr) begin
          failures++;
          $display("FAIL R3 unexpected output: pixel=%0d x=%0d y=%0d expected no output",
                   outPixel, outX, outY);
        end else begin
          if (outPixel != 8'(expVal[rd]) || outX != 8'(expX[rd]) ||
              outY != 8'(expY[rd]) || cyc != expCyc[rd]) begin
            failures++;
            $display("FAIL %s: pixel=%0d x=%0d y=%0d cyc=%0d expected pixel=%0d x=%0d y=%0d cyc=%0d",
                     expTag[rd], outPixel, outX, outY, cyc,
                     expVal[rd], expX[rd], expY[rd], expCyc[rd]);
          end
          rd++;
        end
      end else if (rd < wr && cyc >= expCyc[rd]) begin
        checks++;
        failures++;
        $display("FAIL %s missing output: outValid=0 expected pixel=%0d x=%0d y=%0d",
                 expTag[rd], expVal[rd], expX[rd], expY[rd]);
        rd++;
      end
    end
  end

  initial begin
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        mWin[r][c] = 0;
    repeat (4) @(negedge clk);
    // R1: reset state while held in reset
    checks++;
    if (outValid !== 1'b0 || outPixel !== 8'd0 || outX !== 8'd0 || outY !== 8'd0) begin
      failures++;
      $display("FAIL R1 in reset: valid=%0b pixel=%0d x=%0d y=%0d expected 0 0 0 0",
               outValid, outPixel, outX, outY);
    end
    rstN = 1'b1;
    idle(3);
    checks++;
    if (outValid !== 1'b0 || outPixel !== 8'd0 || outX !== 8'd0 || outY !== 8'd0) begin
      failures++;
      $display("FAIL R1 after reset: valid=%0b pixel=%0d x=%0d y=%0d expected 0 0 0 0",
               outValid, outPixel, outX, outY);
    end

    // R8: columns before the first line start give nothing
    for (int i = 0; i < 5; i++) sendCol(0, 200, 200, 200, "R8");
    idle(4);

    // R3, R4, R5: first line, gapless random data
    sendCol(1, nextRand(), nextRand(), nextRand(), "R3");
    for (int i = 1; i < 8; i++) sendCol(0, nextRand(), nextRand(), nextRand(), "R4 R5");
    idle(3);

    // R2, R6: gaps and a lone lineStart inside a line
    sendCol(1, nextRand(), nextRand(), nextRand(), "R6");
    for (int i = 1; i < 9; i++) begin
      sendCol(0, nextRand(), nextRand(), nextRand(), "R6");
      if (i % 3 == 1) idle(i % 4 + 1);
      if (i == 4) loneLineStart();
    end
    loneLineStart();
    sendCol(0, nextRand(), nextRand(), nextRand(), "R2");
    idle(2);

    // R9: line restarted after a partial window
    sendCol(1, 250, 250, 250, "R9");
    sendCol(0, 250, 250, 250, "R9");
    sendCol(1, 3, 5, 7, "R9");
    sendCol(0, 11, 13, 17, "R9");
    sendCol(0, 19, 23, 29, "R9");
    sendCol(0, 31, 37, 41, "R9");
    sendCol(1, 1, 2, 3, "R9");
    sendCol(0, 9, 9, 9, "R9");
    sendCol(1, 40, 80, 120, "R9");
    for (int i = 1; i < 5; i++) sendCol(0, 60 * i, 30 * i, 10 * i, "R9");
    idle(3);

    // R7, R4: a spike in each row sweeps through all nine taps
    for (int r = 0; r < 3; r++) begin
      sendCol(1, 0, 0, 0, "R7");
      sendCol(0, 0, 0, 0, "R7");
      sendCol(0, (r == 0) ? 255 : 0, (r == 1) ? 255 : 0, (r == 2) ? 255 : 0, "R7");
      sendCol(0, 0, 0, 0, "R7");
      sendCol(0, 0, 0, 0, "R7");
    end
    idle(2);

    // R10: full-scale and all-zero frames
    sendCol(1, 255, 255, 255, "R10");
    for (int i = 1; i < 6; i++) sendCol(0, 255, 255, 255, "R10");
    sendCol(1, 0, 0, 0, "R10");
    for (int i = 1; i < 5; i++) sendCol(0, 0, 0, 0, "R10");

    // R4, R5: random sweep over many lines of varying width
    for (int ln = 0; ln < 60; ln++) begin
      sendCol(1, nextRand(), nextRand(), nextRand(), "R5");
      for (int i = 1; i < 3 + (ln % 11); i++)
        sendCol(0, nextRand(), nextRand(), nextRand(), "R4");
      if (ln % 7 == 3) idle(2);
    end
    idle(6);
    doneFlag = 1;

    // R3: every expected output arrived
    checks++;
    if (rd != wr) begin
      failures++;
      $display("FAIL R3 output count: got=%0d expected=%0d", rd, wr);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule